// File: doc/BRIEF.md
# ISA 16-bit Slave Port

This block is the host-facing slave port of a peripheral on a 16-bit ISA I/O bus. It compares the upper bits of the I/O address with a fixed base address. The match counts only while the address-enable line is low, and a valid match drives an active-low device-select output. The host issues asynchronous read and write strobes. The block routes the data word onto the lower lane, the upper lane or both, according to two active-low byte enables. Only 16-bit accesses are supported.

Each access starts on the host's strobe. The block pulls its ready line low as soon as a strobe falls on a selected address. It releases ready on a clock edge once the internal register bank reports that the access has finished. Both strobes pass through a synchronizer before the access state machine sees them. Write data is taken from the value present just before the write strobe rises, and it is committed to the bank after the synchronized trailing edge. A small scratch register bank with a fixed access latency stands in for the peripheral's own registers. The pad ring builds the tri-state bus from the separate data-in, data-out and per-lane output-enable signals.

Top module: `isa_slave_port`

## Requirements
- R1: `dev_sel_n` is low exactly when `aen` is low and address bits 15..4 equal bits 15..4 of `BASE_ADDR`. An access to any other address changes no register.
- R2: While `aen` is high, the block deselects, holds ready high and enables no data lane. A write strobe issued in that state leaves every register unchanged.
- R3: A selected read with `be_n = 2'b00` sets `data_oe = 2'b11`. `data_out` then holds the full 16-bit register chosen by address bits 3..1.
- R4: A selected read with `be_n = 2'b10` (be_n[0] low, be_n[1] high) sets `data_oe = 2'b01`. This enables only the lower lane, bits 7..0.
- R5: A selected read with `be_n = 2'b01` (be_n[0] high, be_n[1] low) sets `data_oe = 2'b10`. This enables only the upper lane, bits 15..8.
- R6: `data_oe` is `2'b00` whenever `rd_n` is high or the device is not selected.
- R7: A write changes only the byte lanes whose enable is low. The other lanes keep their old value, and a write with `be_n = 2'b11` changes nothing.
- R8: A write stores the data present at the last rising clock edge before `wr_n` rises, even if the data changed earlier during the strobe.
- R9: When a strobe falls on a selected address, `ready` drops without waiting for a clock edge. It rises again at rising edge number `ACC_LAT + 4` after the strobe fell (two synchronizer stages, one start cycle, `ACC_LAT` bank cycles and one completion cycle).
- R10: `ready` is high whenever the device is not selected.
- R11: After reset, every register reads zero, ready is high and no data lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 15 | I/O address bits 15..1 |
| aen | input | 1 | Address enable, decode valid while low |
| be_n | input | 2 | Active-low byte enables: bit 0 lower lane, bit 1 upper lane |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| data_in | input | 16 | Data arriving from the bus |
| data_out | output | 16 | Data sent to the bus on reads |
| data_oe | output | 2 | Per-lane output enable: bit 0 lower, bit 1 upper |
| ready | output | 1 | Channel ready, low inserts wait states |
| dev_sel_n | output | 1 | Active-low local-device select |

## Verification
If the access state machine gets stuck or advances early, the fault shows up on `ready` within a few cycles of a strobe. Ready either stays low past edge `ACC_LAT + 4` or rises before it. A wrong lane mask or a corrupted capture register shows up on the next read of the affected register, as a changed byte or a byte that failed to change. Decode faults show up at once on `dev_sel_n`, and as registers altered by accesses that should have been ignored.

// File: rtl/isa_slave_pkg.sv
package isa_slave_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WAIT = 2'd1,
    ACC_DONE = 2'd2
  } acc_state_t;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode #(
  parameter int          ADDR_W    = 16,
  parameter int          DEC_LSB   = 4,
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  localparam int         IDX_W     = DEC_LSB - 1
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic              aen,
  output logic              sel,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    sel = !aen && (addr[ADDR_W-1:DEC_LSB] == BASE_ADDR[ADDR_W-1:DEC_LSB]);
    idx = addr[DEC_LSB-1:1];
  end
endmodule

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/isa_access_fsm.sv
module isa_access_fsm
  import isa_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic rd_sync_n,
  input  logic wr_sync_n,
  input  logic bank_busy,
  output logic acc_start,
  output logic acc_done,
  output logic wr_commit
);
  acc_state_t state_q, state_d;
  logic       wr_prev_q;
  logic       strobes_idle;

  assign strobes_idle = rd_sync_n && wr_sync_n;

  always_comb begin
    state_d   = state_q;
    acc_start = 1'b0;
    unique case (state_q)
      ACC_IDLE: if (sel && !strobes_idle) begin
        state_d   = ACC_WAIT;
        acc_start = 1'b1;
      end
      ACC_WAIT: begin
        if (strobes_idle)    state_d = ACC_IDLE;
        else if (!bank_busy) state_d = ACC_DONE;
      end
      ACC_DONE: if (strobes_idle) state_d = ACC_IDLE;
      default: state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ACC_IDLE;
      wr_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      wr_prev_q <= wr_sync_n;
    end
  end

  assign acc_done  = (state_q == ACC_DONE);
  assign wr_commit = acc_done && wr_sync_n && !wr_prev_q;
endmodule

// File: rtl/isa_scratch_bank.sv
module isa_scratch_bank
  import isa_slave_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ACC_LAT  = 3,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DATA_W  = LANES * LANE_W,
  localparam int CNT_W   = (ACC_LAT > 0) ? $clog2(ACC_LAT + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  output logic              busy,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DATA_W-1:0] wr_data
);
  logic [CNT_W-1:0]  lat_q;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '0;
    else if (acc_start)      lat_q <= CNT_W'(ACC_LAT);
    else if (lat_q != '0)    lat_q <= lat_q - 1'b1;
  end

  assign busy = (lat_q != '0);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[r][l*LANE_W +: LANE_W] <= '0;
        else if (wr_en && (wr_idx == IDX_W'(r)) && wr_lanes[l])
          regs_q[r][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/isa_slave_port.sv
module isa_slave_port
  import isa_slave_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h0300,
  parameter int          ACC_LAT     = 3,
  parameter int          SYNC_STAGES = 2,
  localparam int         ADDR_W      = 16,
  localparam int         DEC_LSB     = 4,
  localparam int         IDX_W       = DEC_LSB - 1,
  localparam int         NUM_REGS    = 1 << IDX_W,
  localparam int         DATA_W      = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic              aen,
  input  logic [LANES-1:0]  be_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [LANES-1:0]  data_oe,
  output logic              ready,
  output logic              dev_sel_n
);
  logic             sel;
  logic [IDX_W-1:0] idx;
  logic [1:0]       strobe_sync;
  logic             acc_start, acc_done, wr_commit, bank_busy;

  logic [DATA_W-1:0] cap_data_q;
  logic [IDX_W-1:0]  cap_idx_q;
  logic [LANES-1:0]  cap_lanes_q;

  isa_addr_decode #(
    .ADDR_W(ADDR_W), .DEC_LSB(DEC_LSB), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(bus_addr), .aen(aen), .sel(sel), .idx(idx)
  );

  isa_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({wr_n, rd_n}), .sync_out(strobe_sync)
  );

  isa_access_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .rd_sync_n(strobe_sync[0]), .wr_sync_n(strobe_sync[1]),
    .bank_busy(bank_busy), .acc_start(acc_start),
    .acc_done(acc_done), .wr_commit(wr_commit)
  );

  // Capture register: clock enable is the raw write strobe level, so the
  // value left after the last edge before the strobe rises is the one kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data_q  <= '0;
      cap_idx_q   <= '0;
      cap_lanes_q <= '0;
    end else if (!wr_n) begin
      cap_data_q  <= data_in;
      cap_idx_q   <= idx;
      cap_lanes_q <= sel ? ~be_n : '0;
    end
  end

  isa_scratch_bank #(.NUM_REGS(NUM_REGS), .ACC_LAT(ACC_LAT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .acc_start(acc_start), .busy(bank_busy),
    .rd_idx(idx), .rd_data(data_out),
    .wr_en(wr_commit && (cap_lanes_q != '0)),
    .wr_idx(cap_idx_q), .wr_lanes(cap_lanes_q), .wr_data(cap_data_q)
  );

  assign dev_sel_n = !sel;
  assign data_oe   = (sel && !rd_n) ? ~be_n : '0;
  assign ready     = !(sel && (!rd_n || !wr_n) && !acc_done);
endmodule

// File: rtl/isa_slave_port_chk.sv
module isa_slave_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        aen,
  input logic [1:0]  be_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [1:0]  data_oe,
  input logic        ready,
  input logic        dev_sel_n
);
  assert_aen_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (dev_sel_n && ready && (data_oe == 2'b00)));

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || dev_sel_n) |-> (data_oe == 2'b00));

  assert_oe_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_sel_n && !rd_n) |-> (data_oe == ~be_n));

  assert_ready_unsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel_n |-> ready);

  assert_wait_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!dev_sel_n && (!rd_n || !wr_n)));

  assert_wait_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(ready) && !$past(dev_sel_n) && !dev_sel_n) |-> ($past(rd_n) != rd_n || $past(wr_n) != wr_n || $past(!rd_n || !wr_n)));
endmodule

bind isa_slave_port isa_slave_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aen(aen), .be_n(be_n), .rd_n(rd_n),
  .wr_n(wr_n), .data_oe(data_oe), .ready(ready), .dev_sel_n(dev_sel_n)
);

// File: tb/isa_slave_port_tb.sv
module isa_slave_port_tb;
  localparam logic [15:0] BASE = 16'h0300;
  localparam int ACC_LAT    = 3;
  localparam int WAIT_EDGES = ACC_LAT + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] bus_addr = '0;
  logic        aen = 1'b1;
  logic [1:0]  be_n = 2'b11;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic [1:0]  data_oe;
  logic        ready;
  logic        dev_sel_n;

  int    checks = 0;
  int    fails  = 0;
  int    edge_cnt = 0;
  bit    done = 1'b0;
  string data_tag = "R3";
  logic [15:0] model_q [8];

  always #2 clk = ~clk;

  isa_slave_port #(.BASE_ADDR(BASE), .ACC_LAT(ACC_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .aen(aen), .be_n(be_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .ready(ready), .dev_sel_n(dev_sel_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_sel();
    return !aen && (bus_addr[15:4] == BASE[15:4]);
  endfunction

  always @(posedge clk)
    if (rst_n && exp_sel() && (!rd_n || !wr_n)) edge_cnt <= edge_cnt + 1;
    else edge_cnt <= 0;

  // Reference comparison every clock, away from the active edge.
  always @(negedge clk) if (rst_n && !done) begin
    logic [1:0]  eoe;
    logic [15:0] mask;
    bit          s;
    s = exp_sel();
    check(dev_sel_n == !s, "R1", dev_sel_n, !s);
    if (!s) check(ready == 1'b1, aen ? "R2" : "R10", ready, 1);
    else if (!rd_n || !wr_n)
      check(ready == (edge_cnt >= WAIT_EDGES), "R9", ready, edge_cnt >= WAIT_EDGES);
    eoe = (s && !rd_n) ? ~be_n : 2'b00;
    check(data_oe == eoe,
          rd_n ? "R6" : aen ? "R2" : (be_n == 2'b10) ? "R4" : (be_n == 2'b01) ? "R5" : "R3",
          data_oe, eoe);
    if (eoe != 2'b00 && edge_cnt >= WAIT_EDGES) begin
      mask = {{8{eoe[1]}}, {8{eoe[0]}}};
      check((data_out & mask) == (model_q[bus_addr[3:1]] & mask), data_tag,
            data_out & mask, model_q[bus_addr[3:1]] & mask);
    end
  end

  task automatic bus_read(input logic [15:0] a, input logic [1:0] ben, input string tag);
    @(posedge clk); #1;
    bus_addr = a[15:1]; be_n = ben; aen = 1'b0; data_tag = tag;
    @(posedge clk); #1;
    rd_n = 1'b0;
    #0.5 if (exp_sel()) check(ready == 1'b0, "R9", ready, 0);
    repeat (WAIT_EDGES + 2) @(posedge clk);
    #1 rd_n = 1'b1;
    repeat (5) @(posedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [1:0] ben,
                           input logic en_n, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a[15:1]; be_n = ben; aen = en_n; data_in = ~d;
    @(posedge clk); #1;
    wr_n = 1'b0;
    #0.5 if (exp_sel()) check(ready == 1'b0, "R9", ready, 0);
    repeat (3) @(posedge clk);
    #1 data_in = d;
    repeat (WAIT_EDGES) @(posedge clk);
    #1;
    if (exp_sel()) begin
      if (!ben[0]) model_q[a[3:1]][7:0]  = d[7:0];
      if (!ben[1]) model_q[a[3:1]][15:8] = d[15:8];
    end
    wr_n = 1'b1;
    repeat (5) @(posedge clk);
    aen = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model_q[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(ready == 1'b1, "R11", ready, 1);
    check(data_oe == 2'b00, "R11", data_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 8; i++) bus_read(BASE + 16'(2*i), 2'b00, "R11");
    for (int i = 0; i < 8; i++) bus_write(BASE + 16'(2*i), 2'b00, 1'b0, 16'h1111 * 16'(i+1) ^ 16'h5A00);
    for (int i = 0; i < 8; i++) bus_read(BASE + 16'(2*i), 2'b00, "R8");
    bus_write(BASE + 16'h4, 2'b10, 1'b0, 16'hBEEF);
    bus_read(BASE + 16'h4, 2'b00, "R7");
    bus_write(BASE + 16'hA, 2'b01, 1'b0, 16'hC0DE);
    bus_read(BASE + 16'hA, 2'b00, "R7");
    bus_write(BASE + 16'h6, 2'b11, 1'b0, 16'h0000);
    bus_read(BASE + 16'h6, 2'b00, "R7");
    bus_read(BASE + 16'hA, 2'b10, "R4");
    bus_read(BASE + 16'h4, 2'b01, "R5");
    bus_write(BASE + 16'h2, 2'b00, 1'b1, 16'hDEAD);
    bus_read(BASE + 16'h2, 2'b00, "R2");
    bus_write(16'h0402, 2'b00, 1'b0, 16'hFACE);
    bus_read(16'h0402, 2'b00, "R1");
    bus_read(BASE + 16'h2, 2'b00, "R1");
    bus_write(BASE + 16'hE, 2'b00, 1'b0, 16'h0001);
    bus_read(BASE + 16'hE, 2'b00, "R3");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule